// File: doc/BRIEF.md
# Store Queue Commit and Writeback Controller

This block keeps stores in a circular queue from the cycle they are allocated until memory confirms them. Each store enters at the tail with a 16-bit sequence number, an address, a byte size, data and a kind. A commit input names the youngest retired sequence number. Stores at or before that number become eligible to write back. A writeback pointer then hands eligible stores, oldest first, to a memory request port with a valid/ready handshake. A rejected request is held until the memory side signals a retry.

Memory completions may come back in any order. The head of the queue only retires in order, so it pops a run of finished entries. A squash input trims stores that are not yet eligible from the young end. An ordering input forces one store in flight at a time. Some stores finish without any memory traffic: zero-size stores, prefetch-flagged entries and failed conditional stores. Conditional and atomic stores report a result on a response port; plain stores do not.

Top module: `store_queue_ctrl`

## Requirements
- R1: After reset, free_count is 8, pending_count is 0, alloc_ready is 1, and mem_req_valid and resp_valid are 0.
- R2: Slots are numbered 0 to 8, so there is one spare slot. Allocation uses them in ascending order and wraps from 8 to 0; the first allocation after reset takes slot 0. free_count equals 8 minus the occupied entries. When 8 entries are held, alloc_ready is 0 and a further allocation request changes nothing.
- R3: A commit walks the queue from the oldest entry. It marks each non-eligible entry whose sequence number is at or before the commit number, and it stops at the first younger non-eligible entry. pending_count grows by the number of entries marked. Ordering uses the sign of the 16-bit difference, so it is safe across wrap-around.
- R4: At most one request is presented per cycle, in age order. A request needs pending_count to be nonzero, the entry under the pointer to be eligible, and no request to be blocked. mem_req_tag carries the slot number.
- R5: If a request is presented while mem_req_ready is 0, the block stops presenting requests. While mem_retry is 0, mem_req_valid stays low. When mem_retry rises, the same slot is presented again. An accepted request ends the blocked state.
- R6: An eligible entry of size 0, or of kind 3 (prefetch), completes without a request and advances the pointer. Such an immediate completion never takes place in a cycle where cmp_valid is 1.
- R7: While tso_en is 1, no request is presented after one is accepted until a completion arrives.
- R8: A completion (cmp_valid with cmp_tag) finishes its slot and lowers pending_count by one. Completions may arrive out of order, but slots leave the head only in order, and a finished head pops together with every finished slot behind it.
- R9: A squash removes entries from the tail whose sequence number is later than squash_seq. It stops at the first eligible entry. An allocation in the same cycle as a squash is dropped.
- R10: A kind-1 (conditional) store that reaches the pointer with cond_ok at 0 completes without a request. The cycle after, it gives resp_valid with resp_ok 0. Completions of kind 1 or kind 2 (atomic) give resp_valid with resp_ok 1 and resp_seq in the following cycle. Kind 0 (plain) gives no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tso_en | input | 1 | Single-store-in-flight ordering mode |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | 16 | Sequence number of the new store |
| alloc_addr | input | 32 | Store address |
| alloc_size | input | 4 | Size in bytes, 0 means no data |
| alloc_kind | input | 2 | 0 plain, 1 conditional, 2 atomic, 3 prefetch |
| alloc_data | input | 64 | Store data |
| alloc_ready | output | 1 | Queue has a free entry |
| commit_valid | input | 1 | Commit update this cycle |
| commit_seq | input | 16 | Youngest committed sequence number |
| squash_valid | input | 1 | Squash this cycle |
| squash_seq | input | 16 | Last surviving sequence number |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_retry | input | 1 | Memory can take a blocked request again |
| cond_ok | input | 1 | Conditional store may proceed |
| mem_req_addr | output | 32 | Request address |
| mem_req_data | output | 64 | Request data |
| mem_req_size | output | 4 | Request size |
| mem_req_tag | output | 4 | Slot number of the request |
| cmp_valid | input | 1 | Memory completion |
| cmp_tag | input | 4 | Slot number being completed |
| resp_valid | output | 1 | Result for a conditional or atomic store |
| resp_ok | output | 1 | Result succeeded |
| resp_seq | output | 16 | Sequence number of the result |
| free_count | output | 4 | Free entries |
| pending_count | output | 4 | Eligible entries not yet complete |

## Verification
A wrong eligibility mark, either missed or stray, shows up in pending_count in the first cycle after the commit. It also shows up in the next cycle, because a request is presented when none was due, or none is presented when one was. A pointer that slips or fails to hold after a rejection gives a wrong mem_req_tag on the very next presentation. A head that pops out of order, or a squash that crosses an eligible entry, gives a wrong free_count the cycle after the completion or squash. Wrong kind handling gives a wrong resp_valid or resp_ok one cycle after the completion.

// File: rtl/sq_pkg.sv
// Package: shared kinds and wrap-safe sequence ordering for the store queue.
// Assumes sequence numbers in flight span less than half the number space.
package sq_pkg;
    localparam int SEQ_W = 16;

    typedef enum logic [1:0] {
        K_PLAIN    = 2'd0,
        K_COND     = 2'd1,
        K_ATOMIC   = 2'd2,
        K_PREFETCH = 2'd3
    } st_kind_e;

    // True when a is at or before b.
    function automatic logic seq_not_after(input logic [SEQ_W-1:0] a,
                                           input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] d;
        d = b - a;
        return !d[SEQ_W-1];
    endfunction

    // True when a is strictly after b.
    function automatic logic seq_after(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b);
        return !seq_not_after(a, b);
    endfunction
endpackage

// File: rtl/sq_commit_scan.sv
// Commit scan: walks occupied slots oldest first and marks entries that the
// commit number covers. Assumes order[] lists slots from head in age order.
module sq_commit_scan
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = DEPTH + 1,
    parameter int IW    = $clog2(SLOTS)
) (
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic [IW-1:0]    order [DEPTH],
    input  logic [IW-1:0]    occ,
    input  logic [SLOTS-1:0] elig,
    input  logic [SEQ_W-1:0] seq [SLOTS],
    output logic [SLOTS-1:0] mark,
    output logic [IW-1:0]    mark_cnt
);
    logic halt;

    // Mark covered entries until the first younger uncommitted one.
    always_comb begin
        mark     = '0;
        mark_cnt = '0;
        halt     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (commit_valid && !halt && (IW'(i) < occ) && !elig[order[i]]) begin
                if (seq_not_after(seq[order[i]], commit_seq)) begin
                    mark[order[i]] = 1'b1;
                    mark_cnt       = mark_cnt + IW'(1);
                end else begin
                    halt = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sq_squash_scan.sv
// Squash scan: walks occupied slots youngest first and counts entries to drop.
// Assumes order[] lists slots from tail-1 backwards; eligible entries stop it.
module sq_squash_scan
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int SLOTS = DEPTH + 1,
    parameter int IW    = $clog2(SLOTS)
) (
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic [IW-1:0]    order [DEPTH],
    input  logic [IW-1:0]    occ,
    input  logic [SLOTS-1:0] elig,
    input  logic [SEQ_W-1:0] seq [SLOTS],
    output logic [IW-1:0]    kill_cnt
);
    logic halt;

    // Count young uncommitted entries past the squash point.
    always_comb begin
        kill_cnt = '0;
        halt     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (squash_valid && !halt && (IW'(i) < occ)) begin
                if (!elig[order[i]] && seq_after(seq[order[i]], squash_seq))
                    kill_cnt = kill_cnt + IW'(1);
                else
                    halt = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sq_retire_scan.sv
// Retire scan: counts the run of finished entries starting at the head.
// Assumes order[] lists slots from head in age order.
module sq_retire_scan #(
    parameter int DEPTH = 8,
    parameter int SLOTS = DEPTH + 1,
    parameter int IW    = $clog2(SLOTS)
) (
    input  logic [IW-1:0]    order [DEPTH],
    input  logic [IW-1:0]    occ,
    input  logic [SLOTS-1:0] done,
    output logic [IW-1:0]    pop_cnt
);
    logic halt;

    // Count consecutive finished entries from the oldest.
    always_comb begin
        pop_cnt = '0;
        halt    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!halt && (IW'(i) < occ)) begin
                if (done[order[i]]) pop_cnt = pop_cnt + IW'(1);
                else                halt    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/store_queue_ctrl.sv
// Store queue controller: allocation at tail, commit marking, in-order
// writeback with reject/retry, out-of-order completion with in-order head
// retirement, tail squash, and a single-in-flight ordering mode.
// Assumes cmp_tag always names a slot whose request was accepted.
module store_queue_ctrl
    import sq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SZ_W   = 4,
    localparam int SLOTS = DEPTH + 1,
    localparam int IW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tso_en,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SZ_W-1:0]   alloc_size,
    input  logic [1:0]        alloc_kind,
    input  logic [DATA_W-1:0] alloc_data,
    output logic              alloc_ready,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    input  logic              mem_retry,
    input  logic              cond_ok,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_data,
    output logic [SZ_W-1:0]   mem_req_size,
    output logic [IW-1:0]     mem_req_tag,
    input  logic              cmp_valid,
    input  logic [IW-1:0]     cmp_tag,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [SEQ_W-1:0]  resp_seq,
    output logic [IW-1:0]     free_count,
    output logic [IW-1:0]     pending_count
);
    localparam int            IW1     = IW + 1;
    localparam logic [IW:0]   SLOTS_W = IW1'(SLOTS);

    function automatic logic [IW-1:0] slot_add(input logic [IW-1:0] p,
                                               input logic [IW-1:0] n);
        logic [IW:0] t;
        t = {1'b0, p} + {1'b0, n};
        if (t >= SLOTS_W) t = t - SLOTS_W;
        return t[IW-1:0];
    endfunction

    logic [IW-1:0]     head_q, tail_q, wbp_q, pend_q;
    logic [SLOTS-1:0]  elig_q, done_q;
    logic              blocked_q, inflight_q;
    logic              resp_v_q, resp_ok_q;
    logic [SEQ_W-1:0]  resp_seq_q;
    logic [SEQ_W-1:0]  seq_q  [SLOTS];
    logic [ADDR_W-1:0] addr_q [SLOTS];
    logic [DATA_W-1:0] data_q [SLOTS];
    logic [SZ_W-1:0]   size_q [SLOTS];
    st_kind_e          kind_q [SLOTS];

    logic [IW-1:0]     occ, mark_cnt, kill_cnt, pop_cnt;
    logic [SLOTS-1:0]  mark, elig_n, done_n;
    logic [IW-1:0]     fwd_ord [DEPTH];
    logic [IW-1:0]     rev_ord [DEPTH];
    logic              full, alloc_fire;
    logic              cur_live, cur_imm, imm_fire, send_ok, reject;

    // Slot lists in age order from the head and reverse order from the tail.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_order
        assign fwd_ord[gi] = slot_add(head_q, IW'(gi));
        assign rev_ord[gi] = slot_add(tail_q, IW'(SLOTS - 1 - gi));
    end

    // Occupancy from the two pointers; the spare slot separates full from empty.
    always_comb begin
        if (tail_q >= head_q) occ = tail_q - head_q;
        else                  occ = IW'(SLOTS) - head_q + tail_q;
    end

    assign full        = (occ == IW'(DEPTH));
    assign alloc_fire  = alloc_valid && !full && !squash_valid;
    assign alloc_ready = !full;
    assign free_count  = IW'(DEPTH) - occ;
    assign pending_count = pend_q;

    sq_commit_scan #(.DEPTH(DEPTH), .SLOTS(SLOTS), .IW(IW)) u_commit (
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .order(fwd_ord), .occ(occ), .elig(elig_q), .seq(seq_q),
        .mark(mark), .mark_cnt(mark_cnt)
    );

    assign elig_n = elig_q | mark;

    sq_squash_scan #(.DEPTH(DEPTH), .SLOTS(SLOTS), .IW(IW)) u_squash (
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .order(rev_ord), .occ(occ), .elig(elig_n), .seq(seq_q),
        .kill_cnt(kill_cnt)
    );

    // Writeback pointer decision for the entry it currently names.
    always_comb begin
        cur_live = (wbp_q != tail_q) && elig_q[wbp_q] && (pend_q != '0)
                   && !(tso_en && inflight_q);
        cur_imm  = (size_q[wbp_q] == '0) || (kind_q[wbp_q] == K_PREFETCH)
                   || ((kind_q[wbp_q] == K_COND) && !cond_ok);
        imm_fire = !blocked_q && cur_live && cur_imm && !cmp_valid;
        if (blocked_q) mem_req_valid = mem_retry && !(tso_en && inflight_q);
        else           mem_req_valid = cur_live && !cur_imm;
        send_ok  = mem_req_valid && mem_req_ready;
        reject   = mem_req_valid && !mem_req_ready;
    end

    assign mem_req_addr = addr_q[wbp_q];
    assign mem_req_data = data_q[wbp_q];
    assign mem_req_size = size_q[wbp_q];
    assign mem_req_tag  = wbp_q;

    // Finished set including this cycle's completion of either source.
    always_comb begin
        done_n = done_q;
        if (cmp_valid) done_n[cmp_tag] = 1'b1;
        if (imm_fire)  done_n[wbp_q]   = 1'b1;
    end

    sq_retire_scan #(.DEPTH(DEPTH), .SLOTS(SLOTS), .IW(IW)) u_retire (
        .order(fwd_ord), .occ(occ), .done(done_n), .pop_cnt(pop_cnt)
    );

    // Pointer, counter and mode flag state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q     <= '0;
            tail_q     <= '0;
            wbp_q      <= '0;
            pend_q     <= '0;
            blocked_q  <= 1'b0;
            inflight_q <= 1'b0;
        end else begin
            head_q <= slot_add(head_q, pop_cnt);
            if (alloc_fire)
                tail_q <= slot_add(tail_q, IW'(1));
            else if (kill_cnt != '0)
                tail_q <= slot_add(tail_q, IW'(SLOTS) - kill_cnt);
            if (imm_fire || send_ok)
                wbp_q <= slot_add(wbp_q, IW'(1));
            pend_q <= pend_q + mark_cnt - IW'(cmp_valid | imm_fire);
            if (reject)       blocked_q <= 1'b1;
            else if (send_ok) blocked_q <= 1'b0;
            if (tso_en && send_ok) inflight_q <= 1'b1;
            else if (cmp_valid)    inflight_q <= 1'b0;
        end
    end

    // Per-slot eligibility and finished flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elig_q <= '0;
            done_q <= '0;
        end else begin
            elig_q <= elig_n;
            done_q <= done_n;
            if (alloc_fire) begin
                elig_q[tail_q] <= 1'b0;
                done_q[tail_q] <= 1'b0;
            end
        end
    end

    // Payload capture at the tail.
    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            seq_q[tail_q]  <= alloc_seq;
            addr_q[tail_q] <= alloc_addr;
            data_q[tail_q] <= alloc_data;
            size_q[tail_q] <= alloc_size;
            kind_q[tail_q] <= st_kind_e'(alloc_kind);
        end
    end

    // Result report for conditional and atomic stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_v_q   <= 1'b0;
            resp_ok_q  <= 1'b0;
            resp_seq_q <= '0;
        end else begin
            resp_v_q <= 1'b0;
            if (cmp_valid && (kind_q[cmp_tag] == K_COND || kind_q[cmp_tag] == K_ATOMIC)) begin
                resp_v_q   <= 1'b1;
                resp_ok_q  <= 1'b1;
                resp_seq_q <= seq_q[cmp_tag];
            end else if (imm_fire && (kind_q[wbp_q] == K_COND || kind_q[wbp_q] == K_ATOMIC)) begin
                resp_v_q   <= 1'b1;
                resp_ok_q  <= (kind_q[wbp_q] != K_COND) || cond_ok;
                resp_seq_q <= seq_q[wbp_q];
            end
        end
    end

    assign resp_valid = resp_v_q;
    assign resp_ok    = resp_ok_q;
    assign resp_seq   = resp_seq_q;
endmodule

// File: rtl/store_queue_ctrl_chk.sv
// Checker: temporal properties of the store queue ports and ordering flag.
// Assumes it is bound to store_queue_ctrl with matching parameters.
module store_queue_ctrl_chk #(
    parameter int DEPTH = 8,
    parameter int IW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tso_en,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [IW-1:0] mem_req_tag,
    input logic [IW-1:0] free_count,
    input logic [IW-1:0] pending_count,
    input logic          inflight
);
    // R2: free entries never exceed capacity
    a_r2_free_range: assert property (@(posedge clk) disable iff (!rst_n)
        free_count <= IW'(DEPTH));

    // R4: a request is only presented with pending work
    a_r4_pending_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (pending_count != '0));

    // R5: after a rejection only the same slot may be presented next
    a_r5_same_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (!mem_req_valid || mem_req_tag == $past(mem_req_tag)));

    // R7: ordering mode holds requests while one is outstanding
    a_r7_tso_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tso_en && inflight) |-> !mem_req_valid);

    // R8: pending work never exceeds occupied entries
    a_r8_pending_le_occ: assert property (@(posedge clk) disable iff (!rst_n)
        pending_count <= (IW'(DEPTH) - free_count));
endmodule

bind store_queue_ctrl store_queue_ctrl_chk #(.DEPTH(DEPTH), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tso_en(tso_en),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_tag(mem_req_tag), .free_count(free_count),
    .pending_count(pending_count), .inflight(inflight_q)
);

// File: tb/tb_store_queue_ctrl.sv
module tb_store_queue_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tso_en = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [15:0] alloc_seq = '0;
    logic [31:0] alloc_addr = '0;
    logic [3:0]  alloc_size = '0;
    logic [1:0]  alloc_kind = '0;
    logic [63:0] alloc_data = '0;
    logic        alloc_ready;
    logic        commit_valid = 1'b0;
    logic [15:0] commit_seq = '0;
    logic        squash_valid = 1'b0;
    logic [15:0] squash_seq = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_retry = 1'b0;
    logic        cond_ok = 1'b1;
    logic [31:0] mem_req_addr;
    logic [63:0] mem_req_data;
    logic [3:0]  mem_req_size;
    logic [3:0]  mem_req_tag;
    logic        cmp_valid = 1'b0;
    logic [3:0]  cmp_tag = '0;
    logic        resp_valid, resp_ok;
    logic [15:0] resp_seq;
    logic [3:0]  free_count, pending_count;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // commit number (16b) and expected pending count (4b) per row
    localparam logic [19:0] CMT_TBL [5] = '{
        {16'd5,  4'd0}, {16'd15, 4'd1}, {16'd25, 4'd2},
        {16'd25, 4'd2}, {16'd45, 4'd4}
    };

    store_queue_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_alloc(input logic [15:0] s, input logic [3:0] sz, input logic [1:0] k);
        alloc_valid = 1'b1; alloc_seq = s; alloc_addr = 32'h1000 + 32'(s);
        alloc_data = 64'(s); alloc_size = sz; alloc_kind = k;
        step();
        alloc_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [15:0] s);
        commit_valid = 1'b1; commit_seq = s;
        step();
        commit_valid = 1'b0;
    endtask

    task automatic do_squash(input logic [15:0] s);
        squash_valid = 1'b1; squash_seq = s;
        step();
        squash_valid = 1'b0;
    endtask

    task automatic do_cmp(input logic [3:0] t);
        cmp_valid = 1'b1; cmp_tag = t;
        step();
        cmp_valid = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 free", free_count, 8);
        chk("R1 pending", pending_count, 0);
        chk("R1 ready", alloc_ready, 1);
        chk("R1 req", mem_req_valid, 0);
        chk("R1 resp", resp_valid, 0);

        // Table walk: commit marking with the port refusing requests
        do_alloc(16'd10, 4'd4, 2'd0);
        do_alloc(16'd20, 4'd4, 2'd0);
        do_alloc(16'd30, 4'd4, 2'd0);
        do_alloc(16'd40, 4'd4, 2'd0);
        chk("R2 free after 4", free_count, 4);
        chk("R4 no issue uncommitted", mem_req_valid, 0);
        for (int i = 0; i < 5; i++) begin
            do_commit(CMT_TBL[i][19:4]);
            chk("R3 pending after commit", pending_count, 32'(CMT_TBL[i][3:0]));
        end
        chk("R5 blocked holds", mem_req_valid, 0);
        do_squash(16'd0);
        chk("R9 squash stops at eligible", free_count, 4);

        // R5 retry re-presents slot 0, then the rest stream in age order
        mem_retry = 1'b1; mem_req_ready = 1'b1; #1;
        chk("R5 retry valid", mem_req_valid, 1);
        chk("R5 retry tag", mem_req_tag, 0);
        chk("R5 retry addr", mem_req_addr, 32'h100A);
        step();
        mem_retry = 1'b0; #1;
        chk("R4 tag 1", mem_req_tag, 1);
        step(); chk("R4 tag 2", mem_req_tag, 2);
        step(); chk("R4 tag 3", mem_req_tag, 3);
        step(); chk("R4 idle", mem_req_valid, 0);
        chk("R8 pending before cmp", pending_count, 4);

        // R8 out-of-order completion, in-order retirement
        do_cmp(4'd2); chk("R8 free hold", free_count, 4);
        do_cmp(4'd0); chk("R8 pop head", free_count, 5);
        do_cmp(4'd1); chk("R8 pop chain", free_count, 7);
        do_cmp(4'd3); chk("R8 drained", free_count, 8);
        chk("R8 pending zero", pending_count, 0);
        chk("R10 plain no resp", resp_valid, 0);

        // R7 single in flight
        tso_en = 1'b1;
        do_alloc(16'd50, 4'd4, 2'd0);
        do_alloc(16'd60, 4'd4, 2'd0);
        do_commit(16'd60);
        chk("R7 first tag", mem_req_tag, 4);
        chk("R7 first valid", mem_req_valid, 1);
        step(); chk("R7 hold", mem_req_valid, 0);
        step(); chk("R7 hold 2", mem_req_valid, 0);
        do_cmp(4'd4);
        chk("R7 release", mem_req_valid, 1);
        chk("R7 release tag", mem_req_tag, 5);
        step();
        do_cmp(4'd5);
        tso_en = 1'b0;
        chk("R7 drained", free_count, 8);

        // R9 squash from tail
        mem_req_ready = 1'b0;
        do_alloc(16'd70, 4'd4, 2'd0);
        do_alloc(16'd80, 4'd4, 2'd0);
        do_alloc(16'd90, 4'd4, 2'd0);
        do_commit(16'd70);
        do_squash(16'd75);
        chk("R9 squash two", free_count, 7);
        alloc_valid = 1'b1; alloc_seq = 16'd99; alloc_size = 4'd4; alloc_kind = 2'd0;
        do_squash(16'd60);
        alloc_valid = 1'b0;
        chk("R9 eligible kept, alloc dropped", free_count, 7);
        mem_retry = 1'b1; mem_req_ready = 1'b1; #1;
        chk("R5 retry slot 6", mem_req_tag, 6);
        step();
        mem_retry = 1'b0;
        do_cmp(4'd6);
        chk("R9 drained", free_count, 8);

        // R6 and R10 immediate completions and responses
        cond_ok = 1'b0;
        do_alloc(16'd110, 4'd0, 2'd0);
        do_alloc(16'd120, 4'd4, 2'd3);
        do_alloc(16'd130, 4'd4, 2'd1);
        do_alloc(16'd140, 4'd4, 2'd2);
        do_commit(16'd140);
        chk("R6 pending", pending_count, 4);
        chk("R6 size zero no req", mem_req_valid, 0);
        step(); chk("R6 size zero retired", free_count, 5);
        chk("R6 prefetch no req", mem_req_valid, 0);
        step(); chk("R6 prefetch retired", free_count, 6);
        chk("R10 cond fail no req", mem_req_valid, 0);
        step(); chk("R10 cond retired", free_count, 7);
        chk("R10 fail resp", resp_valid, 1);
        chk("R10 fail ok", resp_ok, 0);
        chk("R10 fail seq", resp_seq, 130);
        chk("R4 atomic req", mem_req_valid, 1);
        chk("R4 atomic tag", mem_req_tag, 1);
        step(); chk("R10 resp one cycle", resp_valid, 0);
        do_cmp(4'd1);
        chk("R10 atomic resp", resp_valid, 1);
        chk("R10 atomic ok", resp_ok, 1);
        chk("R10 atomic seq", resp_seq, 140);
        chk("R8 special drained", free_count, 8);
        cond_ok = 1'b1;

        // R2 full queue
        for (int i = 0; i < 8; i++) do_alloc(16'(200 + i), 4'd4, 2'd0);
        chk("R2 full free", free_count, 0);
        chk("R2 full ready", alloc_ready, 0);
        do_alloc(16'd208, 4'd4, 2'd0);
        chk("R2 alloc when full ignored", free_count, 0);
        do_squash(16'd199);
        chk("R9 squash all", free_count, 8);

        // R3 wrap-safe ordering
        mem_req_ready = 1'b0;
        do_alloc(16'hFFF0, 4'd4, 2'd0);
        do_alloc(16'h0005, 4'd4, 2'd0);
        do_commit(16'hFFFF);
        chk("R3 wrap commit", pending_count, 1);
        do_squash(16'hFFF8);
        chk("R9 wrap squash", free_count, 7);
        mem_retry = 1'b1; mem_req_ready = 1'b1; #1;
        chk("R2 slot wrap tag", mem_req_tag, 2);
        step();
        mem_retry = 1'b0;
        do_cmp(4'd2);
        chk("R8 final free", free_count, 8);
        chk("R8 final pending", pending_count, 0);

        summary();
    end
endmodule